// File: doc/BRIEF.md
# Sector Hamming Code Generator

This block produces a three-byte single-error-correcting Hamming code for one 512-byte sector of flash data. Data bytes are offered one per clock with a valid strobe. Each accepted byte updates two accumulators. One is a 9-bit row value: the index of every byte with odd parity is XORed into it. The other is a running XOR of all the bytes. When the last byte of a sector is accepted, the block folds that byte in, derives the primed and unprimed parity pairs, and packs them into a fixed interleaved 24-bit word. It inverts every bit of that word, registers the result on the code output and raises a one-cycle completion pulse. The accumulators then clear themselves, so the next sector can follow at once.

A controller uses the block while it streams a sector to or from the flash array. It pulses the restart input at the start of each transfer, or whenever a transfer is abandoned. It then reads the code in the cycle the completion pulse is high, or at any later time before the next sector completes. Comparing codes, correcting data and placing codes in the spare area are done elsewhere.

Top module: `hamming_sector_ecc`

## Requirements
- R1: A code covers exactly 512 accepted bytes. The clock edge that accepts the 512th byte also loads the code output and raises doneOut, and doneOut is high for that single cycle only.
- R2: For every accepted byte with odd parity, the byte's index within the sector (0 to 511) is XORed into a 9-bit row value. Bit k of the row value is the unprimed row parity P(8·2^k).
- R3: The primed row parities equal the row value when the XOR of all 512 bytes has even parity, and equal its bitwise complement when that XOR has odd parity.
- R4: The column parities are the parities of the XOR of all bytes under these masks: P1 0xAA, P1' 0x55, P2 0xCC, P2' 0x33, P4 0xF0, P4' 0x0F.
- R5: Before inversion, codeOut[23:16] holds P4, P4', P2, P2', P1, P1' in bits 23 down to 18, row bit 8 in bit 17 and its primed partner in bit 16. codeOut[15:8] holds row bits 7 down to 4, each followed by its primed partner. codeOut[7:0] holds row bits 3 down to 0 in the same way. A single flipped data bit therefore changes exactly 12 code bits.
- R6: Every code bit is inverted on output. An all-0xFF sector and an all-0x00 sector both give 0xFFFFFF, and codeOut reads 0xFFFFFF after reset.
- R7: A byte presented with byteValid low is ignored. It neither changes the code nor advances the byte index.
- R8: startIn clears both accumulators and the byte index. A byte presented in the same cycle as startIn is discarded. Bytes of a sector that is abandoned this way have no effect on any later code.
- R9: codeOut changes only at the completion of a sector and holds its value at all other times, including across startIn.
- R10: After the 512th byte the index wraps to 0, so a byte accepted in the next cycle starts a new sector without any startIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Restart: clears the accumulators and the byte index |
| byteValid | input | 1 | byteIn holds a sector byte this cycle |
| byteIn | input | 8 | Sector data byte |
| codeOut | output | 24 | Inverted Hamming code of the last completed sector |
| doneOut | output | 1 | One-cycle pulse when codeOut takes a new code |

## Verification
The bench computes the expected code straight from the Hamming definitions. It XORs the parity of each byte into unprimed or primed row terms according to each index bit, and each data bit into column terms, so an error in the shortcut of XORing indexes or deriving the primes from global parity shows up as a mismatch. Sectors with one flipped bit at the first byte, the last byte and a middle byte must change exactly 12 code bits. A wrong interleave, or a missing or doubled inversion, would break that count or the erased-sector value of 0xFFFFFF. Idle gaps carry garbage data and a start is raised in the middle of a sector. A design that samples byteIn without byteValid, advances the index on idle cycles, or keeps the partial sums would produce the wrong code. Two sectors sent back to back show whether the index wraps and the accumulators clear without a start.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

  // Per-cycle commands from the control to the datapath
  typedef struct packed {
    logic clearAcc;  // restart: drop partial sums
    logic takeByte;  // fold the presented byte into the sums
    logic lastByte;  // the folded byte closes the sector
  } eccStrobe_t;

endpackage

// File: rtl/hecc_ctrl.sv
module hecc_ctrl
  import hecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int IDX_W = $clog2(SECTOR_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             byteValid,
  output eccStrobe_t       strb,
  output logic [IDX_W-1:0] byteIdx,
  output logic             doneOut
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SECTOR_BYTES - 1);

  logic takeNow;
  logic lastNow;

  // Start wins over a byte in the same cycle
  assign takeNow = byteValid && !startIn;
  assign lastNow = takeNow && (byteIdx == LAST_IDX);

  always_comb begin
    strb.clearAcc = startIn;
    strb.takeByte = takeNow;
    strb.lastByte = lastNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx <= '0;
    end else if (startIn || lastNow) begin
      byteIdx <= '0;
    end else if (takeNow) begin
      byteIdx <= byteIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneOut <= 1'b0;
    else       doneOut <= lastNow;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);  // R1
  AST_IDLE_HOLDS_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    (!startIn && !byteValid) |=> $stable(byteIdx));  // R7
  AST_START_ZEROES_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> (byteIdx == '0));  // R8
  AST_INDEX_WRAPS: assert property (@(posedge clk) disable iff (!rstN)
    strb.lastByte |=> (byteIdx == '0));  // R10

endmodule

// File: rtl/hecc_pack.sv
module hecc_pack #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 9,
  localparam int COL_LVLS = $clog2(DATA_W),
  localparam int PAIRS    = COL_LVLS + IDX_W,
  localparam int CODE_W   = 2 * PAIRS
) (
  input  logic [IDX_W-1:0]  rowPar,
  input  logic [DATA_W-1:0] xorByte,
  output logic [CODE_W-1:0] codeWord
);

  logic             globalOdd;
  logic [IDX_W-1:0] rowPrime;
  logic [COL_LVLS-1:0] colHi;
  logic [COL_LVLS-1:0] colLo;
  logic [CODE_W-1:0]   rawCode;

  assign globalOdd = ^xorByte;
  assign rowPrime  = rowPar ^ {IDX_W{globalOdd}};

  // Column parity: bit positions with level bit set / clear
  always_comb begin
    colHi = '0;
    colLo = '0;
    for (int lvl = 0; lvl < COL_LVLS; lvl++) begin
      for (int pos = 0; pos < DATA_W; pos++) begin
        if (((pos >> lvl) & 1) == 1) colHi[lvl] = colHi[lvl] ^ xorByte[pos];
        else                         colLo[lvl] = colLo[lvl] ^ xorByte[pos];
      end
    end
  end

  // Row pairs occupy the low bits, column pairs above them
  for (genvar r = 0; r < IDX_W; r++) begin : g_rowPair
    assign rawCode[2*r+1] = rowPar[r];
    assign rawCode[2*r]   = rowPrime[r];
  end
  for (genvar c = 0; c < COL_LVLS; c++) begin : g_colPair
    assign rawCode[2*(IDX_W+c)+1] = colHi[c];
    assign rawCode[2*(IDX_W+c)]   = colLo[c];
  end

  assign codeWord = ~rawCode;

endmodule

// File: rtl/hecc_datapath.sv
module hecc_datapath
  import hecc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 9,
  localparam int CODE_W = 2 * ($clog2(DATA_W) + IDX_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  eccStrobe_t        strb,
  input  logic [IDX_W-1:0]  byteIdx,
  input  logic [DATA_W-1:0] byteIn,
  output logic [CODE_W-1:0] codeOut
);

  logic [IDX_W-1:0]  rowAcc;
  logic [DATA_W-1:0] xorAcc;
  logic [IDX_W-1:0]  rowNext;
  logic [DATA_W-1:0] xorNext;
  logic [CODE_W-1:0] codeNext;

  assign rowNext = rowAcc ^ ((^byteIn) ? byteIdx : '0);
  assign xorNext = xorAcc ^ byteIn;

  // Packing sees the sums including the closing byte
  hecc_pack #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_pack (
    .rowPar  (rowNext),
    .xorByte (xorNext),
    .codeWord(codeNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowAcc <= '0;
      xorAcc <= '0;
    end else if (strb.clearAcc || strb.lastByte) begin
      rowAcc <= '0;
      xorAcc <= '0;
    end else if (strb.takeByte) begin
      rowAcc <= rowNext;
      xorAcc <= xorNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              codeOut <= '1;
    else if (strb.lastByte) codeOut <= codeNext;
  end

  AST_CLEAR_EMPTIES_SUMS: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAcc |=> (rowAcc == '0 && xorAcc == '0));  // R8
  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lastByte |=> $stable(codeOut));  // R9
  AST_NEW_SECTOR_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strb.lastByte |=> (rowAcc == '0 && xorAcc == '0));  // R10

endmodule

// File: rtl/hamming_sector_ecc.sv
module hamming_sector_ecc
  import hecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic startIn,
  input  logic byteValid,
  input  logic [DATA_W-1:0] byteIn,
  output logic [2*($clog2(DATA_W)+$clog2(SECTOR_BYTES))-1:0] codeOut,
  output logic doneOut
);

  localparam int IDX_W = $clog2(SECTOR_BYTES);

  eccStrobe_t       strb;
  logic [IDX_W-1:0] byteIdx;

  hecc_ctrl #(.SECTOR_BYTES(SECTOR_BYTES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .byteValid(byteValid),
    .strb     (strb),
    .byteIdx  (byteIdx),
    .doneOut  (doneOut)
  );

  hecc_datapath #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .byteIdx(byteIdx),
    .byteIn (byteIn),
    .codeOut(codeOut)
  );

endmodule

// File: tb/hamming_sector_ecc_tb.sv
module hamming_sector_ecc_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteIn = '0;
  logic [23:0] codeOut;
  logic doneOut;

  int checks = 0;
  int fails = 0;
  int holdViolations = 0;
  logic [23:0] expQ[$];
  string tagQ[$];
  logic [7:0] sec [512];

  always #10 clk = ~clk;  // 50 MHz

  hamming_sector_ecc u_dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .byteValid(byteValid),
    .byteIn(byteIn), .codeOut(codeOut), .doneOut(doneOut)
  );

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %06h expected %06h", req, act, exp);
    end
  endtask

  // Reference built directly from the parity definitions
  function automatic logic [23:0] refCode();
    logic [8:0] rowHi = '0, rowLo = '0;
    logic [2:0] colHi = '0, colLo = '0;
    logic [7:0] b2, b1, b0;
    for (int b = 0; b < 512; b++) begin
      for (int k = 0; k < 9; k++)
        if (b[k]) rowHi[k] ^= ^sec[b]; else rowLo[k] ^= ^sec[b];
      for (int j = 0; j < 8; j++)
        for (int l = 0; l < 3; l++)
          if (((j >> l) & 1) == 1) colHi[l] ^= sec[b][j]; else colLo[l] ^= sec[b][j];
    end
    b2 = {colHi[2], colLo[2], colHi[1], colLo[1], colHi[0], colLo[0], rowHi[8], rowLo[8]};
    b1 = {rowHi[7], rowLo[7], rowHi[6], rowLo[6], rowHi[5], rowLo[5], rowHi[4], rowLo[4]};
    b0 = {rowHi[3], rowLo[3], rowHi[2], rowLo[2], rowHi[1], rowLo[1], rowHi[0], rowLo[0]};
    return ~{b2, b1, b0};
  endfunction

  // Driver: push expectation, then stream the sector
  task automatic sendSector(input bit gaps, input string tag);
    expQ.push_back(refCode());
    tagQ.push_back(tag);
    for (int i = 0; i < 512; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk);
        byteValid = 1'b0;
        byteIn = 8'($urandom);  // garbage on idle cycle (R7)
      end
      @(negedge clk);
      byteValid = 1'b1;
      byteIn = sec[i];
    end
    @(negedge clk);
    byteValid = 1'b0;
    byteIn = 8'($urandom);
  endtask

  // Monitor: compare on done, watch pulse width and hold
  logic prevDone = 1'b0;
  logic [23:0] prevCode = 24'hFFFFFF;
  always @(negedge clk) begin
    if (rstN) begin
      if (doneOut) begin
        if (prevDone) check(1'b0, "R1 done wider than one cycle", codeOut, codeOut);
        if (expQ.size() == 0) begin
          check(1'b0, "R1 unexpected done", codeOut, 24'h0);
        end else begin
          automatic logic [23:0] e = expQ.pop_front();
          automatic string t = tagQ.pop_front();
          check(codeOut === e, t, codeOut, e);
        end
      end else if (codeOut !== prevCode) begin
        holdViolations++;
      end
      prevDone = doneOut;
      prevCode = codeOut;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [23:0] base, flipped;
    repeat (3) @(negedge clk);
    // Reset state (R6)
    check(codeOut === 24'hFFFFFF, "R6 reset code", codeOut, 24'hFFFFFF);
    check(doneOut === 1'b0, "R1 reset done", {23'h0, doneOut}, 24'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Erased and zero sectors (R6)
    foreach (sec[i]) sec[i] = 8'hFF;
    check(refCode() == 24'hFFFFFF, "R6 erased reference", refCode(), 24'hFFFFFF);
    sendSector(1'b0, "R6 erased sector");
    foreach (sec[i]) sec[i] = 8'h00;
    sendSector(1'b0, "R6 zero sector");

    // Lone bit at index 0 and lone bit at index 511 (R2 R3 R4)
    sec[0] = 8'h01;
    sendSector(1'b0, "R4 lone bit byte0");
    sec[0] = 8'h00; sec[511] = 8'h80;
    sendSector(1'b0, "R2 lone bit byte511");
    sec[511] = 8'h00;

    // Random sector and single-bit flips (R2 R3 R5)
    foreach (sec[i]) sec[i] = 8'($urandom);
    sendSector(1'b0, "R3 random sector");
    @(negedge clk);
    base = codeOut;
    for (int f = 0; f < 3; f++) begin
      automatic int pos = (f == 0) ? 0 : (f == 1) ? 511 : 300;
      automatic int bitn = (f == 0) ? 0 : (f == 1) ? 7 : 3;
      sec[pos][bitn] = ~sec[pos][bitn];
      sendSector(1'b0, "R5 flipped sector");
      @(negedge clk);
      flipped = codeOut;
      check($countones(base ^ flipped) == 12, "R5 twelve bits differ", base ^ flipped, 24'h0);
      sec[pos][bitn] = ~sec[pos][bitn];
    end

    // Gaps with garbage data (R7)
    foreach (sec[i]) sec[i] = 8'($urandom);
    sendSector(1'b1, "R7 sector with gaps");

    // Abandoned partial sector, start with a byte in the same cycle (R8 R9)
    @(negedge clk);
    base = codeOut;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      byteValid = 1'b1;
      byteIn = 8'($urandom);
    end
    @(negedge clk);
    startIn = 1'b1; byteValid = 1'b1; byteIn = 8'hA5;
    @(negedge clk);
    startIn = 1'b0; byteValid = 1'b0;
    check(codeOut === base, "R9 code held across partial and start", codeOut, base);
    foreach (sec[i]) sec[i] = 8'($urandom);
    sendSector(1'b0, "R8 sector after restart");

    // Back to back sectors without start (R10)
    foreach (sec[i]) sec[i] = 8'($urandom);
    expQ.push_back(refCode()); tagQ.push_back("R10 first of pair");
    for (int i = 0; i < 512; i++) begin
      @(negedge clk); byteValid = 1'b1; byteIn = sec[i];
    end
    foreach (sec[i]) sec[i] = 8'($urandom);
    sendSector(1'b0, "R10 second of pair");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R1 all sectors completed", 24'(expQ.size()), 24'h0);
    check(holdViolations == 0, "R9 code stable between completions", 24'(holdViolations), 24'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule